// File: doc/BRIEF.md
# Operand Addressing Unit

This block resolves a single operand for a 16-bit CPU whose registers live in a register file. A decoder hands it three things: the mode field of either the source or the destination operand, a register number, and a size flag. The unit then reads the register file. When the mode carries an extension word, it also fetches that word from the instruction stream. The result is either the operand value itself or an effective address for the data path to use. Where the mode post-increments a pointer register, the unit also produces the write-back for it.

Three modes have no encoding of their own. Each one reuses a general encoding with a special base register:

- Register 0 is the program counter. Indexed mode with register 0 becomes relative-to-PC addressing.
- Register 2 is the status register. In indexed mode it contributes a base of zero, so the extension word becomes an absolute address.
- Auto-increment through register 0 becomes an immediate constant.

The unit keeps its own fetch pointer. It loads this pointer from the caller at start, advances it past every extension word consumed, and hands it back when the operand completes.

Top module: `operand_addr_unit`

## Requirements
- R1: While reset is asserted and right after it, `done`, `mem_req` and `wb_en` are 0.
- R2: Mode 00 returns the contents of the register as `value` with `is_addr`=0. It fetches no extension word and performs no write-back. With `byte_op`=1 the value is the low byte zero-extended; with `byte_op`=0 it is the full word.
- R3: Mode 01 on any register other than 0 or 2 fetches one extension word X at `pc_in`. It returns `ea` = register + X with `is_addr`=1.
- R4: Mode 01 on register 0 uses the address of the extension word (`pc_in`) as the base, so `ea` = `pc_in` + X.
- R5: Mode 01 on register 2 uses a base of zero, so `ea` = X regardless of the register contents.
- R6: Mode 10 returns `ea` = register contents with `is_addr`=1. It fetches nothing and performs no write-back.
- R7: Mode 11 on a register other than 0 returns `ea` equal to the register before the increment. In the same `done` cycle it raises `wb_en` with `wb_reg` = that register and `wb_data` = register + 1 for `byte_op`=1, or + 2 for `byte_op`=0.
- R8: Mode 11 on register 0 fetches the word at `pc_in` and returns it as `value` with `is_addr`=0. With `byte_op`=1 the value is the low byte zero-extended. No write-back is raised.
- R9: With `is_dst`=1 only `mode[0]` is decoded: 0 selects register mode and 1 selects indexed mode. `mode[1]` has no effect.
- R10: `pc_next` equals `pc_in` plus 2 for each extension word consumed.
- R11: `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is seen. `done` does not rise before that.
- R12: `done` is a single-cycle pulse for each accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving an operand; accepted when idle |
| is_dst | input | 1 | 1: destination mode field (one bit), 0: source field |
| mode | input | 2 | Mode field: 00 register, 01 indexed, 10 indirect, 11 auto-increment |
| reg_sel | input | 4 | Register number (0 = PC, 2 = SR) |
| byte_op | input | 1 | 1 = byte operation, 0 = word operation |
| pc_in | input | 16 | Address of the first word after the instruction |
| rf_raddr | output | 4 | Register file read address |
| rf_rdata | input | 16 | Register file read data |
| mem_req | output | 1 | Extension word fetch request |
| mem_addr | output | 16 | Extension word address |
| mem_ack | input | 1 | Fetch completes this cycle |
| mem_rdata | input | 16 | Fetched extension word |
| done | output | 1 | Result valid pulse |
| is_addr | output | 1 | 1: `ea` is valid, 0: `value` is valid |
| ea | output | 16 | Effective address |
| value | output | 16 | Operand value |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_reg | output | 4 | Write-back register number |
| wb_data | output | 16 | Incremented pointer |
| pc_next | output | 16 | Fetch pointer after the operand |

## Verification
Two pairs of events can fall in the same cycle.

In auto-increment mode, the effective address and the pointer write-back appear in one `done` cycle. The bench provokes this with pointer registers in both sizes and judges both outputs in that cycle: `ea` must hold the value before the increment, and `wb_data` must hold the incremented one.

In the indexed, relative and immediate modes, the extension fetch and the fetch pointer advance land on the same acknowledge edge. The bench checks that the relative base is the address before the advance, and that `pc_next` reflects exactly one step. A stretched acknowledge exercises the held request.

// File: rtl/oau_pkg.sv
package oau_pkg;
  localparam int unsigned REG_PC = 0;
  localparam int unsigned REG_SR = 2;

  typedef enum logic [2:0] {
    K_REG  = 3'd0,
    K_IDX  = 3'd1,
    K_SYM  = 3'd2,
    K_ABS  = 3'd3,
    K_IND  = 3'd4,
    K_AINC = 3'd5,
    K_IMM  = 3'd6
  } kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } state_e;
endpackage

// File: rtl/oau_decode.sv
module oau_decode
  import oau_pkg::*;
#(
  parameter int unsigned RW = 4
) (
  input  logic          is_dst,
  input  logic [1:0]    mode,
  input  logic [RW-1:0] regn,
  output kind_e         kind,
  output logic          needs_ext
);
  logic [1:0] eff_mode;
  logic       reg_is_pc;
  logic       reg_is_sr;

  always_comb begin
    eff_mode  = is_dst ? {1'b0, mode[0]} : mode;
    reg_is_pc = (regn == RW'(REG_PC));
    reg_is_sr = (regn == RW'(REG_SR));
    unique case (eff_mode)
      2'b00: kind = K_REG;
      2'b01: begin
        if (reg_is_pc)      kind = K_SYM;
        else if (reg_is_sr) kind = K_ABS;
        else                kind = K_IDX;
      end
      2'b10: kind = K_IND;
      default: kind = reg_is_pc ? K_IMM : K_AINC;
    endcase
    needs_ext = (kind == K_IDX) || (kind == K_SYM) ||
                (kind == K_ABS) || (kind == K_IMM);
  end
endmodule

// File: rtl/oau_fetch.sv
module oau_fetch #(
  parameter int unsigned AW   = 16,
  parameter int unsigned STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_ptr,
  input  logic          want,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          got,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    mem_req  = want;
    mem_addr = ptr_q;
    got      = want && mem_ack;
    ptr_en   = load || got;
    ptr_d    = load ? load_ptr : ptr_q + AW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !load) |=> (ptr == $past(ptr) + AW'(STEP)));
endmodule

// File: rtl/oau_calc.sv
module oau_calc
  import oau_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned BW = 8
) (
  input  kind_e         kind,
  input  logic          byte_op,
  input  logic [DW-1:0] rf_data,
  input  logic [DW-1:0] ext,
  input  logic [DW-1:0] ext_addr,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] value,
  output logic          is_addr,
  output logic          wb_flag,
  output logic [DW-1:0] wb_data
);
  localparam int unsigned INC_B = 1;
  localparam int unsigned INC_W = DW / BW;

  logic [DW-1:0] base;
  logic [DW-1:0] raw_val;

  always_comb begin
    ea      = '0;
    raw_val = '0;
    is_addr = 1'b1;
    wb_flag = 1'b0;
    base    = rf_data;
    unique case (kind)
      K_SYM:  base = ext_addr;
      K_ABS:  base = '0;
      default: base = rf_data;
    endcase
    unique case (kind)
      K_REG: begin
        raw_val = rf_data;
        is_addr = 1'b0;
      end
      K_IDX, K_SYM, K_ABS: ea = base + ext;
      K_IND:  ea = rf_data;
      K_AINC: begin
        ea      = rf_data;
        wb_flag = 1'b1;
      end
      K_IMM: begin
        raw_val = ext;
        is_addr = 1'b0;
      end
      default: ea = '0;
    endcase
    value   = byte_op ? {{(DW-BW){1'b0}}, raw_val[BW-1:0]} : raw_val;
    wb_data = rf_data + (byte_op ? DW'(INC_B) : DW'(INC_W));
  end
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import oau_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_dst,
  input  logic [1:0]    mode,
  input  logic [RW-1:0] reg_sel,
  input  logic          byte_op,
  input  logic [DW-1:0] pc_in,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          is_addr,
  output logic [DW-1:0] ea,
  output logic [DW-1:0] value,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_data,
  output logic [DW-1:0] pc_next
);
  localparam int unsigned STEP = DW / 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  state_e        state_q, state_d;
  kind_e         kind_dec, kind_q;
  logic          ext_dec, ext_q;
  logic [RW-1:0] reg_q;
  logic          byte_q;
  logic          accept;
  logic          complete;
  logic          got;
  logic          want;

  kind_e         c_kind;
  logic [DW-1:0] c_ea, c_value, c_wb_data;
  logic          c_is_addr, c_wb_flag;

  logic          done_q;
  logic          is_addr_q, wb_flag_q;
  logic [DW-1:0] ea_q, value_q, wb_data_q;

  oau_decode #(.RW(RW)) u_dec (
    .is_dst    (is_dst),
    .mode      (mode),
    .regn      (reg_sel),
    .kind      (kind_dec),
    .needs_ext (ext_dec)
  );

  oau_fetch #(.AW(DW), .STEP(STEP)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (accept),
    .load_ptr (pc_in),
    .want     (want),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .got      (got),
    .ptr      (pc_next)
  );

  assign c_kind = kind_q;

  oau_calc #(.DW(DW)) u_calc (
    .kind     (c_kind),
    .byte_op  (byte_q),
    .rf_data  (rf_rdata),
    .ext      (mem_rdata),
    .ext_addr (mem_addr),
    .ea       (c_ea),
    .value    (c_value),
    .is_addr  (c_is_addr),
    .wb_flag  (c_wb_flag),
    .wb_data  (c_wb_data)
  );

  // next state
  always_comb begin
    accept   = (state_q == ST_IDLE) && start;
    want     = (state_q == ST_EXEC) && ext_q;
    complete = (state_q == ST_EXEC) && (!ext_q || got);
    state_d  = state_q;
    if (accept)        state_d = ST_EXEC;
    else if (complete) state_d = ST_IDLE;
    rf_raddr = reg_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= complete;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      kind_q <= K_REG;
      ext_q  <= 1'b0;
      reg_q  <= '0;
      byte_q <= 1'b0;
    end else if (accept) begin
      kind_q <= kind_dec;
      ext_q  <= ext_dec;
      reg_q  <= reg_sel;
      byte_q <= byte_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ea_q      <= '0;
      value_q   <= '0;
      is_addr_q <= 1'b0;
      wb_flag_q <= 1'b0;
      wb_data_q <= '0;
    end else if (complete) begin
      ea_q      <= c_ea;
      value_q   <= c_value;
      is_addr_q <= c_is_addr;
      wb_flag_q <= c_wb_flag;
      wb_data_q <= c_wb_data;
    end
  end

  assign done    = done_q;
  assign is_addr = is_addr_q;
  assign ea      = ea_q;
  assign value   = value_q;
  assign wb_en   = done_q && wb_flag_q;
  assign wb_reg  = reg_q;
  assign wb_data = wb_data_q;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done);

  // R7
  wb_delta_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    wb_en |-> ((wb_data - ea) == (byte_q ? DW'(1) : DW'(STEP))));

  // R7
  wb_is_addr_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    wb_en |-> (is_addr && done));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (!done && !mem_req));
endmodule

// File: tb/tb_operand_addr_unit.sv
module tb_operand_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, is_dst, byte_op;
  logic [1:0]  mode;
  logic [3:0]  reg_sel;
  logic [15:0] pc_in;
  logic [3:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        mem_req, mem_ack;
  logic [15:0] mem_addr, mem_rdata;
  logic        done, is_addr, wb_en;
  logic [15:0] ea, value, wb_data, pc_next;
  logic [3:0]  wb_reg;
  logic        ack_en;

  int n_chk = 0;
  int n_fail = 0;
  int n_fetch = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  operand_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_dst(is_dst), .mode(mode),
    .reg_sel(reg_sel), .byte_op(byte_op), .pc_in(pc_in),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .is_addr(is_addr), .ea(ea),
    .value(value), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .pc_next(pc_next)
  );

  function automatic logic [15:0] regval(input logic [3:0] r);
    if (r == 4'd2) return 16'h0007;
    if (r == 4'd5) return 16'h80FF;
    return 16'h1000 + {8'h00, r, 4'h0} * 16'h0011;
  endfunction

  function automatic logic [15:0] memval(input logic [15:0] a);
    return (a * 16'd3) ^ 16'hA5C3;
  endfunction

  assign rf_rdata  = regval(rf_raddr);
  assign mem_ack   = mem_req && ack_en;
  assign mem_rdata = memval(mem_addr);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ack) n_fetch <= n_fetch + 1;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stimulus: {is_dst, mode[1:0], byte_op, reg[3:0], pc[15:0]}
  localparam int NV = 22;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 2'b00, 1'b0, 4'd5,  16'h0200},  // R2 word
    {1'b0, 2'b00, 1'b1, 4'd5,  16'h0200},  // R2 byte
    {1'b0, 2'b01, 1'b0, 4'd4,  16'h0300},  // R3
    {1'b0, 2'b01, 1'b1, 4'd9,  16'h0310},  // R3 byte
    {1'b0, 2'b01, 1'b0, 4'd0,  16'h0400},  // R4
    {1'b0, 2'b01, 1'b1, 4'd0,  16'h0402},  // R4 byte
    {1'b0, 2'b01, 1'b0, 4'd2,  16'h0500},  // R5
    {1'b0, 2'b01, 1'b1, 4'd2,  16'h0506},  // R5 byte
    {1'b0, 2'b10, 1'b0, 4'd6,  16'h0600},  // R6
    {1'b0, 2'b10, 1'b1, 4'd15, 16'h0600},  // R6 byte
    {1'b0, 2'b11, 1'b0, 4'd7,  16'h0700},  // R7 word
    {1'b0, 2'b11, 1'b1, 4'd7,  16'h0700},  // R7 byte
    {1'b0, 2'b11, 1'b1, 4'd5,  16'h0700},  // R7 byte, carry into high byte
    {1'b0, 2'b11, 1'b0, 4'd0,  16'h0800},  // R8 word
    {1'b0, 2'b11, 1'b1, 4'd0,  16'h0804},  // R8 byte
    {1'b1, 2'b00, 1'b0, 4'd5,  16'h0900},  // R9 dst register
    {1'b1, 2'b10, 1'b1, 4'd5,  16'h0900},  // R9 mode[1] ignored -> register
    {1'b1, 2'b01, 1'b0, 4'd4,  16'h0A00},  // R9 dst indexed
    {1'b1, 2'b11, 1'b1, 4'd8,  16'h0A10},  // R9 mode[1] ignored -> indexed
    {1'b1, 2'b01, 1'b0, 4'd0,  16'h0B00},  // R9 dst symbolic
    {1'b1, 2'b01, 1'b1, 4'd2,  16'h0B20},  // R9 dst absolute
    {1'b0, 2'b01, 1'b0, 4'd14, 16'hFFFE}   // R10 pointer wrap
  };

  task automatic run_vec(input logic [23:0] v, input int stall);
    logic        d  = v[23];
    logic [1:0]  m  = v[22:21];
    logic        b  = v[20];
    logic [3:0]  r  = v[19:16];
    logic [15:0] pc = v[15:0];
    logic [1:0]  em = d ? {1'b0, m[0]} : m;
    logic [15:0] rv = regval(r);
    logic [15:0] x  = memval(pc);
    logic [15:0] e_ea = 16'h0, e_val = 16'h0, e_wbd = 16'h0;
    logic        e_addr = 1'b1, e_wb = 1'b0;
    int          e_f = 0;
    int          w = 0;
    case (em)
      2'b00: begin e_addr = 1'b0; e_val = b ? {8'h00, rv[7:0]} : rv; end
      2'b01: begin
        e_f = 1;
        e_ea = (r == 4'd0) ? pc + x : (r == 4'd2) ? x : rv + x;
      end
      2'b10: e_ea = rv;
      default: begin
        if (r == 4'd0) begin
          e_f = 1; e_addr = 1'b0; e_val = b ? {8'h00, x[7:0]} : x;
        end else begin
          e_ea = rv; e_wb = 1'b1; e_wbd = rv + (b ? 16'd1 : 16'd2);
        end
      end
    endcase
    @(negedge clk);
    n_fetch = 0;
    ack_en  = (stall == 0);
    start = 1'b1; is_dst = d; mode = m; byte_op = b; reg_sel = r; pc_in = pc;
    @(negedge clk);
    start = 1'b0;
    if (stall > 0) begin
      for (int i = 0; i < stall; i++) begin
        chk("R11 req held", {15'h0, mem_req}, 16'h1);
        chk("R11 addr stable", mem_addr, pc);
        chk("R11 no early done", {15'h0, done}, 16'h0);
        @(negedge clk);
      end
      ack_en = 1'b1;
    end
    while (!done && w < 40) begin @(negedge clk); w++; end
    chk("R12 done seen", {15'h0, done}, 16'h1);
    chk("R2/R8 is_addr", {15'h0, is_addr}, {15'h0, e_addr});
    if (e_addr) chk("R3-6 ea", ea, e_ea);
    else        chk("R2 R8 value", value, e_val);
    chk("R7 wb_en", {15'h0, wb_en}, {15'h0, e_wb});
    if (e_wb) begin
      chk("R7 wb_reg", {12'h0, wb_reg}, {12'h0, r});
      chk("R7 wb_data", wb_data, e_wbd);
    end
    chk("R10 pc_next", pc_next, pc + 16'(2 * e_f));
    chk("R10 fetch count", 16'(n_fetch), 16'(e_f));
    @(negedge clk);
    chk("R12 single pulse", {15'h0, done}, 16'h0);
    ack_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_dst = 1'b0; mode = 2'b00;
    reg_sel = 4'd0; byte_op = 1'b0; pc_in = 16'h0; ack_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {15'h0, done}, 16'h0);
    chk("R1 mem_req in reset", {15'h0, mem_req}, 16'h0);
    chk("R1 wb_en in reset", {15'h0, wb_en}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", {15'h0, done}, 16'h0);
    chk("R1 mem_req after reset", {15'h0, mem_req}, 16'h0);

    for (int k = 0; k < NV; k++) run_vec(VEC[k], 0);

    // R11: stretched acknowledge on indexed, relative and immediate fetches
    run_vec({1'b0, 2'b01, 1'b0, 4'd4, 16'h0C00}, 3);
    run_vec({1'b0, 2'b01, 1'b1, 4'd0, 16'h0C40}, 2);
    run_vec({1'b0, 2'b11, 1'b0, 4'd0, 16'h0C80}, 4);

    // R1: reset in the middle of a stalled fetch
    @(negedge clk);
    ack_en = 1'b0; start = 1'b1; mode = 2'b01; reg_sel = 4'd4; is_dst = 1'b0; pc_in = 16'h0D00;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-fetch reset done", {15'h0, done}, 16'h0);
    chk("R1 mid-fetch reset req", {15'h0, mem_req}, 16'h0);
    rst_n = 1'b1; ack_en = 1'b1;
    repeat (4) @(negedge clk);
    run_vec({1'b0, 2'b11, 1'b0, 4'd11, 16'h0E00}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule